// File: doc/BRIEF.md
# Self-Correcting Ring Counter

This block is a 4-stage ring counter built on a shift register. It passes a single active bit from stage to stage, one stage per enabled clock, and returns to its 4-state cycle from any pattern. The bit that enters the bottom stage is computed from the three lower stages rather than taken from the top stage. An illegal pattern is therefore pushed out of the register within a few clocks, and no separate error detector is needed.

A build-time parameter selects the active level. With `INVERT = 0` a single 1 moves through a field of 0s. With `INVERT = 1` a single 0 moves through a field of 1s. The counter has a synchronous active-high reset, a count enable and a parallel load. The load lets the surrounding logic place any 4-bit pattern into the register, including illegal ones. The raw state is an output, and so is a decoded phase vector. The decoded vector has one line per stage, active at the level the parameter selects.

Top module: `ring_sc_counter`

## Requirements
- R1: On a clock edge with `rst` high, `q` becomes 4'b0001 when `INVERT = 0` and 4'b1110 when `INVERT = 1`, regardless of `ld` and `en`.
- R2: On an enabled shift edge (`rst` low, `ld` low, `en` high), the new `q[3:1]` equals the old `q[2:0]`. Data moves from bit 0 toward bit 3.
- R3: With `INVERT = 0`, the bit entering `q[0]` on a shift is 1 when the old `q[2:0]` is 3'b000 and 0 otherwise.
- R4: With `INVERT = 1`, the bit entering `q[0]` on a shift is 0 when the old `q[2:0]` is 3'b111 and 1 otherwise.
- R5: With `rst` and `ld` low and `en` low, `q` keeps its value.
- R6: With `rst` low and `ld` high, `q` takes `ld_val` on the edge, whether `en` is high or low.
- R7: From the reset pattern, the counter visits exactly 4 distinct states and is back at the reset pattern after 4 enabled clocks.
- R8: From any of the 16 patterns, the counter reaches a valid state within at most 3 enabled clocks. A valid state has exactly one bit at the active level. Once valid, the counter stays valid on every later shift.
- R9: `phase[i]` follows `q[i]` for every i. In a valid state, exactly one `phase` line is at the active level: 1 for `INVERT = 0`, 0 for `INVERT = 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, top priority |
| en | input | 1 | Count enable |
| ld | input | 1 | Parallel load strobe, beats `en` |
| ld_val | input | 4 | Pattern written on a load |
| q | output | 4 | Register state |
| phase | output | 4 | Decoded phase lines, one per stage |

## Verification
The counter is run from its reset pattern in both polarities. This shows whether the shift direction and the entering bit produce the 4-state cycle and the return to the seed. Each of the 16 patterns is then loaded and the counter is stepped. The number of clocks to a valid state separates a correct feedback, which never needs more than 3, from one that recirculates the top bit or tests the wrong stages. Last, the bench applies enable-low stretches and reset, load and enable together. These cases separate holding from shifting and show which control wins when more than one is asserted.

// File: rtl/ring_sc_pkg.sv
package ring_sc_pkg;

    localparam int RING_W = 4;
    localparam int LOW_W  = RING_W - 1;

    typedef logic [RING_W-1:0] ring_t;
    typedef logic [LOW_W-1:0]  ring_low_t;

    typedef struct packed {
        logic rst;
        logic ld;
        logic en;
    } ring_ctl_t;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2,
        OP_HOLD  = 2'd3
    } ring_op_e;

    // Seed: a single token at stage 0, at the polarity's active level.
    function automatic ring_t seed_pattern(input bit inv);
        ring_t one_tok;
        one_tok = ring_t'(1);
        return inv ? ~one_tok : one_tok;
    endfunction

    // Bit entering stage 0: NOR of the low stages, or NAND when inverted.
    function automatic logic serial_in(input ring_low_t low, input bit inv);
        return inv ? ~(&low) : ~(|low);
    endfunction

    function automatic ring_op_e pick_op(input ring_ctl_t c);
        if (c.rst)     return OP_RESET;
        else if (c.ld) return OP_LOAD;
        else if (c.en) return OP_SHIFT;
        else           return OP_HOLD;
    endfunction

endpackage

// File: rtl/ring_sc_feed.sv
module ring_sc_feed
    import ring_sc_pkg::*;
#(
    parameter bit INVERT = 1'b0
) (
    input  ring_t cur,
    output ring_t shifted
);
    ring_low_t low_bits;
    logic      fb_bit;

    assign low_bits = cur[LOW_W-1:0];
    assign fb_bit   = serial_in(low_bits, INVERT);
    assign shifted  = {low_bits, fb_bit};
endmodule

// File: rtl/ring_sc_core.sv
module ring_sc_core
    import ring_sc_pkg::*;
#(
    parameter bit INVERT = 1'b0
) (
    input  logic      clk,
    input  ring_ctl_t ctl,
    input  ring_t     load_pat,
    input  ring_t     shift_pat,
    output ring_t     state
);
    ring_op_e op;
    ring_t    nxt;

    assign op = pick_op(ctl);

    always_comb begin
        unique case (op)
            OP_RESET: nxt = seed_pattern(INVERT);
            OP_LOAD:  nxt = load_pat;
            OP_SHIFT: nxt = shift_pat;
            default:  nxt = state;
        endcase
    end

    always_ff @(posedge clk) begin
        state <= nxt;
    end
endmodule

// File: rtl/ring_sc_tap.sv
module ring_sc_tap
    import ring_sc_pkg::*;
(
    input  ring_t cur,
    output ring_t lines
);
    for (genvar i = 0; i < RING_W; i++) begin : g_tap
        assign lines[i] = cur[i];
    end
endmodule

// File: rtl/ring_sc_counter.sv
module ring_sc_counter
    import ring_sc_pkg::*;
#(
    parameter bit INVERT = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       ld,
    input  logic [3:0] ld_val,
    output logic [3:0] q,
    output logic [3:0] phase
);
    ring_ctl_t ctl;
    ring_t     cur;
    ring_t     shifted;

    assign ctl = '{rst: rst, ld: ld, en: en};

    ring_sc_feed #(.INVERT(INVERT)) u_feed (
        .cur     (cur),
        .shifted (shifted)
    );

    ring_sc_core #(.INVERT(INVERT)) u_core (
        .clk       (clk),
        .ctl       (ctl),
        .load_pat  (ld_val),
        .shift_pat (shifted),
        .state     (cur)
    );

    ring_sc_tap u_tap (
        .cur   (cur),
        .lines (phase)
    );

    assign q = cur;
endmodule

// File: rtl/ring_sc_chk.sv
module ring_sc_chk #(
    parameter bit INVERT = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       ld,
    input logic [3:0] ld_val,
    input logic [3:0] q,
    input logic [3:0] phase
);
    localparam logic [3:0] SEED = INVERT ? 4'b1110 : 4'b0001;
    localparam int         ACT_ONES = INVERT ? 3 : 1;

    logic       is_valid;
    logic [2:0] bad_run;

    assign is_valid = ($countones(q) == ACT_ONES);

    // Consecutive enabled clocks spent in an illegal state.
    always_ff @(posedge clk) begin
        if (rst || ld)        bad_run <= 3'd0;
        else if (en) begin
            if (is_valid)     bad_run <= 3'd0;
            else if (bad_run != 3'd7) bad_run <= bad_run + 3'd1;
        end
    end

    AST_RESET_SEED: assert property (@(posedge clk) rst |=> (q == SEED)); // R1

    AST_SHIFT_DIR: assert property (@(posedge clk) disable iff (rst)
        (!ld && en) |=> (q[3:1] == $past(q[2:0]))); // R2

    AST_FEED_NOR: assert property (@(posedge clk) disable iff (rst)
        (!INVERT && !ld && en) |=> (q[0] == ($past(q[2:0]) == 3'b000))); // R3

    AST_FEED_NAND: assert property (@(posedge clk) disable iff (rst)
        (INVERT && !ld && en) |=> (q[0] == ($past(q[2:0]) != 3'b111))); // R4

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ld && !en) |=> $stable(q)); // R5

    AST_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld |=> (q == $past(ld_val))); // R6

    AST_STAY_VALID: assert property (@(posedge clk) disable iff (rst)
        (is_valid && !ld && en) |=> is_valid); // R8

    AST_RECOVER_LIMIT: assert property (@(posedge clk) disable iff (rst)
        bad_run <= 3'd3); // R8

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        is_valid |-> $onehot(INVERT ? ~phase : phase)); // R9
endmodule

bind ring_sc_counter ring_sc_chk #(.INVERT(INVERT)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .ld     (ld),
    .ld_val (ld_val),
    .q      (q),
    .phase  (phase)
);

// File: tb/sim_ring_sc_counter.sv
`timescale 1ns/1ps
module sim_ring_sc_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic       ld  = 1'b0;
    logic [3:0] ldv0 = 4'd0;
    logic [3:0] ldv1 = 4'd0;
    logic [3:0] q0, q1, ph0, ph1;

    int checks = 0;
    int fails  = 0;
    int m0 = 0;
    int m1 = 0;
    string tag = "R1";
    bit done = 1'b0;

    always #10 clk = ~clk;

    ring_sc_counter #(.INVERT(1'b0)) u0 (
        .clk(clk), .rst(rst), .en(en), .ld(ld), .ld_val(ldv0),
        .q(q0), .phase(ph0)
    );
    ring_sc_counter #(.INVERT(1'b1)) u1 (
        .clk(clk), .rst(rst), .en(en), .ld(ld), .ld_val(ldv1),
        .q(q1), .phase(ph1)
    );

    function automatic int model_next(int s, bit inv, bit r, bit l, int lv, bit e);
        int low;
        int fb;
        if (r) return inv ? 14 : 1;
        if (l) return lv;
        if (!e) return s;
        low = s % 8;
        if (inv) fb = (low != 7) ? 1 : 0;
        else     fb = (low == 0) ? 1 : 0;
        return ((s * 2) % 16) + fb;
    endfunction

    function automatic bit valid_pat(int s, bit inv);
        int ones = 0;
        for (int i = 0; i < 4; i++) if (((s >> i) % 2) == 1) ones++;
        return inv ? (ones == 3) : (ones == 1);
    endfunction

    task automatic check(bit ok, string t, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    // One clock: model follows the held inputs, outputs compared at the falling edge.
    task automatic step();
        @(posedge clk);
        m0 = model_next(m0, 1'b0, rst, ld, int'(ldv0), en);
        m1 = model_next(m1, 1'b1, rst, ld, int'(ldv1), en);
        @(negedge clk);
        check(int'(q0) == m0, {tag, " pol0 q"}, q0, m0);
        check(int'(q1) == m1, {tag, " pol1 q"}, q1, m1);
        check(ph0 == q0, "R9 pol0 phase", ph0, q0);
        check(ph1 == q1, "R9 pol1 phase", ph1, q1);
    endtask

    initial begin
        #(20ns * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seen0;
        int steps;
        @(negedge clk);
        // R1 reset seeds
        tag = "R1";
        rst = 1'b1; en = 1'b1; ld = 1'b0;
        step(); step();
        check(q0 == 4'b0001, "R1 pol0 seed", q0, 1);
        check(q1 == 4'b1110, "R1 pol1 seed", q1, 14);
        rst = 1'b0;

        // R2 R3 R4 R7 free run
        tag = "R2 R3 R4 R7";
        seen0 = 0;
        for (int k = 1; k <= 8; k++) begin
            step();
            seen0 = seen0 | (1 << q0);
            if (k == 4) begin
                check(q0 == 4'b0001, "R7 pol0 period", q0, 1);
                check(q1 == 4'b1110, "R7 pol1 period", q1, 14);
            end
            if (k == 1) begin
                check(q0 == 4'b0010, "R3 pol0 first shift", q0, 2);
                check(q1 == 4'b1101, "R4 pol1 first shift", q1, 13);
            end
        end
        check(seen0 == 32'h0116, "R7 pol0 distinct states", seen0, 32'h0116);

        // R5 hold
        tag = "R5";
        en = 1'b0;
        for (int k = 0; k < 3; k++) step();
        check(q0 == 4'b0001, "R5 pol0 hold", q0, 1);

        // R5 R1 reset beats load and enable
        tag = "R1 R5";
        en = 1'b1; ld = 1'b1; ldv0 = 4'b1010; ldv1 = 4'b0101; rst = 1'b1;
        step();
        check(q1 == 4'b1110, "R1 pol1 reset over load", q1, 14);
        rst = 1'b0;

        // R6 load with enable low and high
        tag = "R6";
        en = 1'b0;
        step();
        check(q0 == 4'b1010, "R6 pol0 load en low", q0, 10);
        en = 1'b1; ldv0 = 4'b0110; ldv1 = 4'b1001;
        step();
        check(q1 == 4'b1001, "R6 pol1 load en high", q1, 9);
        ld = 1'b0;

        // R8 recovery from every pattern
        for (int v = 0; v < 16; v++) begin
            tag = "R6";
            ld = 1'b1; ldv0 = 4'(v); ldv1 = 4'(v);
            step();
            ld = 1'b0;
            tag = "R8";
            steps = 0;
            while (!valid_pat(int'(q0), 1'b0) && steps < 6) begin step(); steps++; end
            check(steps <= 3, "R8 pol0 recovery clocks", steps, 3);
            for (int k = 0; k < 4; k++) begin
                step();
                check(valid_pat(int'(q0), 1'b0), "R8 pol0 stays valid", q0, m0);
                check($countones(ph0) == 1, "R9 pol0 one active line", $countones(ph0), 1);
            end
            steps = 0;
            ld = 1'b1;
            step();
            ld = 1'b0;
            while (!valid_pat(int'(q1), 1'b1) && steps < 6) begin step(); steps++; end
            check(steps <= 3, "R8 pol1 recovery clocks", steps, 3);
            for (int k = 0; k < 4; k++) begin
                step();
                check(valid_pat(int'(q1), 1'b1), "R8 pol1 stays valid", q1, m1);
                check($countones(~ph1) == 1, "R9 pol1 one active line", $countones(~ph1), 1);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule